// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a serial PHY management link. Software places one complete, already encoded 32-bit management frame in the data register. The block then clocks out a preamble and that frame on the management clock and data pins. If the opcode field of the frame marks a read, the block stops driving the data line from the second turnaround bit onward and shifts in the sixteen bits the PHY returns. Those bits replace the low half of the data register.

The management clock comes from a half-period count held in the speed register, so one clock period lasts twice that many system clocks. When a frame is finished, a sticky done flag is set in the event register. Software clears the flag by writing a one to its bit. A speed value of zero holds the clock idle and prevents any frame from starting.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A write to the data register (bus_addr 0) while idle and with a nonzero speed value starts a frame. The frame opens with 32 MDC periods in which mdio_oe is 1 and mdio_o is 1.
- R2: After the preamble, the 32 frame bits are sent most significant bit first, one per MDC period. A frame whose bits [29:28] are not 2'b10 is driven for all 32 bits.
- R3: For a read frame (bits [29:28] = 2'b10), mdio_oe is 1 for frame bits 31 down to 17 and 0 for bits 16 down to 0. The 16 bits sampled during frame bits 15..0, MSB first, then appear in data[15:0], while data[31:16] keep the written word.
- R4: A read to which no PHY responds (mdio_i held at 1) leaves 16'hFFFF in data[15:0].
- R5: While a frame runs, each MDC period lasts exactly 2 × speed system clocks, and MDC starts each frame low. A frame has exactly 64 rising edges, and MDC is 0 whenever no frame is running.
- R6: mdio_o changes during a frame only together with a falling MDC edge. mdio_i is sampled on rising MDC edges.
- R7: At frame end, bit 23 of the event register (bus_addr 2) becomes 1. It stays 1 until a write to the event register with bit 23 set. Writes with bit 23 clear leave it unchanged.
- R8: A write to the data register while a frame is running is ignored. The frame on the pins and the final register value are those of the original word.
- R9: While the speed value is 0, a data-register write is ignored: no frame starts, MDC stays 0 and the data register keeps its value.
- R10: The speed register (bus_addr 1) reads back the low SPEED_W bits last written, with upper bits 0. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 speed, 2 event |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
Frames are swept over half-period counts 1 to 4. For each count, write frames with mixed, all-zero and all-one payloads are sent, along with reads answered by a responder with two different data words and a read to an absent PHY. Comparing the observed bit streams with the expected enable masks distinguishes a read from a write. The measured period spacing separates correct division from off-by-one counting. The mixed payload words expose swapped or shifted bit order. Further runs cover a write to the busy block, a speed of zero, and partial-mask writes to the event register, each probing one rule for ignoring input.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int WORD_W       = 32;
    localparam int PRE_LEN      = 32;
    localparam int DATA_W       = 16;
    localparam int EVT_DONE_BIT = 23;
    localparam logic [1:0] OPC_READ = 2'b10;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_SPEED = 2'd1,
        SEL_EVENT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk_lvl;
    } gen_t;

    gen_t q, d;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        d        = q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        last_cnt = half - 1'b1;
        if (!run) begin
            d.cnt     = '0;
            d.clk_lvl = 1'b0;
        end else if (half == '0) begin
            d = q;
        end else if (q.cnt >= last_cnt) begin
            d.cnt     = '0;
            d.clk_lvl = ~q.clk_lvl;
            rise_stb  = ~q.clk_lvl;
            fall_stb  = q.clk_lvl;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.clk_lvl;

    // R5: a stopped generator brings the clock low on the next edge
    a_r5_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R5: the counter never passes the programmed half period
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && half != '0 && $stable(half)) |-> (q.cnt <= last_cnt));
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_BITS  = PRE_LEN,
    parameter int FRAME_W   = WORD_W,
    parameter int RDATA_W   = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] word,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [RDATA_W-1:0] rd_data
);
    localparam int TOTAL   = PRE_BITS + FRAME_W;
    localparam int IDX_W   = $clog2(TOTAL);
    localparam int REL_IDX = PRE_BITS + FRAME_W - RDATA_W - 1;
    localparam int CAP_IDX = REL_IDX + 1;

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] shreg;
        logic               is_rd;
        logic               o;
        logic               oe;
        logic [RDATA_W-1:0] cap;
    } seq_t;

    seq_t q, d;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        d    = q;
        done = 1'b0;
        nxt  = q.idx + 1'b1;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.idx   = '0;
                d.shreg = word;
                d.is_rd = (word[FRAME_W-3 -: 2] == OPC_READ);
                d.o     = 1'b1;
                d.oe    = 1'b1;
                d.cap   = '0;
            end
        end else begin
            if (rise_stb && q.is_rd && q.idx >= IDX_W'(CAP_IDX)) begin
                d.cap = {q.cap[RDATA_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (q.idx == IDX_W'(TOTAL - 1)) begin
                    d.busy = 1'b0;
                    d.o    = 1'b1;
                    d.oe   = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.idx = nxt;
                    if (nxt >= IDX_W'(PRE_BITS)) begin
                        d.o     = q.shreg[FRAME_W-1];
                        d.shreg = {q.shreg[FRAME_W-2:0], 1'b0};
                    end
                    d.oe = !(q.is_rd && nxt >= IDX_W'(REL_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, idx: '0, shreg: '0, is_rd: 1'b0,
                   o: 1'b1, oe: 1'b0, cap: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign mdio_o  = q.o;
    assign mdio_oe = q.oe;
    assign rd_data = q.cap;

    // R1: preamble positions are driven high
    a_r1_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx < IDX_W'(PRE_BITS)) |-> (q.o && q.oe));

    // R2: a non-read frame keeps the line driven for its whole length
    a_r2_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !q.is_rd) |-> q.oe);

    // R3: a read frame leaves the line released from the second turnaround bit on
    a_r3_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.is_rd && q.idx >= IDX_W'(REL_IDX)) |-> !q.oe);

    // R6: output data only moves on a falling clock strobe
    a_r6_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy) && !$stable(q.o)) |-> $past(fall_stb));

    // R5: a clock edge never has both directions at once
    a_r5_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));
endmodule

// File: rtl/mdio_frame_ctrl.sv
`timescale 1ns/1ps
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int SPEED_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [WORD_W-1:0]  data;
        logic [SPEED_W-1:0] speed;
        logic               evt;
    } ctl_t;

    ctl_t q, d;
    reg_sel_e sel;
    logic start;
    logic busy;
    logic done;
    logic rise_stb;
    logic fall_stb;
    logic [DATA_W-1:0] rd_data;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        d     = q;
        start = 1'b0;
        if (bus_wr) begin
            case (sel)
                SEL_DATA: begin
                    if (!busy && q.speed != '0) begin
                        d.data = bus_wdata;
                        start  = 1'b1;
                    end
                end
                SEL_SPEED: d.speed = bus_wdata[SPEED_W-1:0];
                SEL_EVENT: if (bus_wdata[EVT_DONE_BIT]) d.evt = 1'b0;
                default: ;
            endcase
        end
        if (done) begin
            d.evt = 1'b1;
            if (q.data[WORD_W-3 -: 2] == OPC_READ) d.data[DATA_W-1:0] = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA:  bus_rdata = q.data;
            SEL_SPEED: bus_rdata[SPEED_W-1:0] = q.speed;
            SEL_EVENT: bus_rdata[EVT_DONE_BIT] = q.evt;
            default:   bus_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.CNT_W(SPEED_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half     (q.speed),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word     (bus_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    // R5: clock rests low between frames
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mdc);

    // R7: the done flag holds unless cleared by a write with its bit set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.evt) && !$past(bus_wr && sel == SEL_EVENT && bus_wdata[EVT_DONE_BIT]))
        |-> q.evt);

    // R8: data writes during a frame leave the register alone
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && bus_wr && sel == SEL_DATA) |=> (q.data == $past(q.data)));

    // R9: zero speed keeps the block idle
    a_r9_speed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && q.speed == '0) |=> !busy);
endmodule

// File: tb/sim_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_frame_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    bit          phy_present = 1'b0;
    bit          phy_rd = 1'b0;
    logic [15:0] phy_data = 16'h0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign mdio_i = phy_en ? phy_bit : 1'b1;

    mdio_frame_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // line monitor and responder
    longint cyc = 0;
    longint last_rise = 0;
    int rises = 0;
    int rise_base = 0;
    int bad_period = 0;
    int period_base = 0;
    int contention = 0;
    int cont_base = 0;
    int exp_half = 1;
    logic [63:0] seen = '0;
    logic [63:0] seen_oe = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (phy_en && mdio_oe) contention = contention + 1;
    end

    always @(posedge mdc) begin
        int k;
        k = rises - rise_base;
        if (k < 64) begin
            seen[63-k]    = mdio_o;
            seen_oe[63-k] = mdio_oe;
        end
        if (k > 0 && (cyc - last_rise) != longint'(2 * exp_half)) bad_period = bad_period + 1;
        last_rise = cyc;
        rises = rises + 1;
    end

    always @(negedge mdc) begin
        int k;
        k = rises - rise_base;
        if (phy_present && phy_rd && k >= 47 && k <= 63) begin
            phy_en  = 1'b1;
            phy_bit = (k == 47) ? 1'b0 : phy_data[63-k];
        end else begin
            phy_en = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] mk_rd(input logic [4:0] p, input logic [4:0] r);
        return 32'h6002_0000 | (32'(p) << 23) | (32'(r) << 18);
    endfunction

    function automatic logic [31:0] mk_wr(input logic [4:0] p, input logic [4:0] r,
                                          input logic [15:0] v);
        return 32'h5002_0000 | (32'(p) << 23) | (32'(r) << 18) | 32'(v);
    endfunction

    task automatic run_frame(input int spd, input logic [31:0] word, input bit present,
                             input logic [15:0] pdata, input bit intrude);
        logic [31:0] r;
        logic [31:0] exp_oe;
        logic [31:0] exp_data;
        bit rd;
        int n;
        rd = (word[29:28] == 2'b10);
        bus_write(2'd1, 32'(spd));
        exp_half    = spd;
        phy_rd      = rd;
        phy_present = present;
        phy_data    = pdata;
        rise_base   = rises;
        period_base = bad_period;
        cont_base   = contention;
        bus_write(2'd0, word);
        if (intrude) begin
            repeat (30) @(negedge clk);
            bus_write(2'd0, 32'h5FFF_FFFF); // R8 write during frame
        end
        n = 0;
        do begin
            bus_read(2'd2, r);
            n++;
        end while (!r[23] && n < 3000);
        chk(r[23] == 1'b1, "R7", "done flag after frame", r, 32'h0080_0000);
        chk(rises - rise_base == 64, "R5", "rising edges per frame", 32'(rises - rise_base), 32'd64);
        chk(seen[63:32] == 32'hFFFF_FFFF && seen_oe[63:32] == 32'hFFFF_FFFF, "R1",
            "preamble bits", seen[63:32] & seen_oe[63:32], 32'hFFFF_FFFF);
        exp_oe = rd ? 32'hFFFE_0000 : 32'hFFFF_FFFF;
        chk(seen_oe[31:0] == exp_oe, rd ? "R3" : "R2", "drive enable mask", seen_oe[31:0], exp_oe);
        chk((seen[31:0] & exp_oe) == (word & exp_oe), intrude ? "R8" : "R2", "frame bits",
            seen[31:0] & exp_oe, word & exp_oe);
        chk(bad_period == period_base, "R5", "MDC period", 32'(bad_period - period_base), 32'd0);
        chk(contention == cont_base, "R3", "line contention", 32'(contention - cont_base), 32'd0);
        chk(mdc == 1'b0, "R5", "MDC low after frame", 32'(mdc), 32'd0);
        exp_data = rd ? {word[31:16], (present ? pdata : 16'hFFFF)} : word;
        bus_read(2'd0, r);
        chk(r == exp_data, rd ? (present ? "R3" : "R4") : (intrude ? "R8" : "R2"),
            "data register after frame", r, exp_data);
        bus_write(2'd2, 32'hFF7F_FFFF); // R7 mask without done bit
        bus_read(2'd2, r);
        chk(r == 32'h0080_0000, "R7", "flag kept by write of 0", r, 32'h0080_0000);
        bus_write(2'd2, 32'h0080_0000);
        bus_read(2'd2, r);
        chk(r == 32'h0, "R7", "flag cleared by write of 1", r, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        bus_read(2'd0, r); chk(r == 0, "R10", "data after reset", r, 0);
        bus_read(2'd1, r); chk(r == 0, "R10", "speed after reset", r, 0);
        bus_read(2'd2, r); chk(r == 0, "R10", "event after reset", r, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R5", "pins idle after reset",
            {30'd0, mdc, mdio_oe}, 32'd0);

        // R9 zero speed blocks a frame
        base = rises;
        bus_write(2'd0, mk_wr(5'd1, 5'd2, 16'h1357));
        repeat (300) @(negedge clk);
        chk(rises == base, "R9", "no MDC edges at speed 0", 32'(rises - base), 0);
        bus_read(2'd2, r); chk(r == 0, "R9", "no done flag at speed 0", r, 0);
        bus_read(2'd0, r); chk(r == 0, "R9", "data unchanged at speed 0", r, 0);

        // R10 speed readback
        bus_write(2'd1, 32'hFFFF_FF5A);
        bus_read(2'd1, r); chk(r == 32'h5A, "R10", "speed readback", r, 32'h5A);

        // sweep of half-period counts and frame patterns
        for (int s = 1; s <= 4; s++) begin
            run_frame(s, mk_wr(5'd5, 5'd3, 16'hA5C3), 1'b0, 16'h0, 1'b0);
            run_frame(s, mk_rd(5'd9, 5'd2), 1'b1, 16'h1234, 1'b0);
            run_frame(s, mk_rd(5'd17, 5'd21), 1'b0, 16'h0, 1'b0);
            run_frame(s, mk_wr(5'd31, 5'd31, 16'hFFFF), 1'b0, 16'h0, 1'b0);
            run_frame(s, mk_rd(5'd0, 5'd0), 1'b1, 16'h8001, 1'b0);
            run_frame(s, mk_wr(5'd0, 5'd0, 16'h0000), 1'b0, 16'h0, 1'b0);
        end

        // R8 writes during a running frame
        run_frame(2, mk_rd(5'd12, 5'd7), 1'b1, 16'hBEEF, 1'b1);
        run_frame(3, mk_wr(5'd3, 5'd30, 16'h0F0F), 1'b0, 16'h0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule